// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt sources, masks them, and presents them to a processor on two outputs: a normal interrupt line and a fast interrupt line. Each source is the OR of a level-sensitive hardware input and a software-set request bit. Per-source enable and soft-request bits are changed through paired write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write. A select register steers each source to the fast or the normal line.

Normal-line sources can be given a handler address through sixteen prioritised vector slots. Slot 0 is the most urgent. Reading the vector register returns the handler address of the most urgent request that may run now and puts that level into service. Writing the vector register acknowledges the level in service and returns to the level below it. Sources that no enabled slot names share one default address. The default level is the least urgent level. Levels nest, so a more urgent slot can preempt a handler that is already running.

Software reaches the block over a simple 32-bit register bus. Reads return data one cycle after the access. A fixed identification word can be read as four bytes.

Top module: `vic_top`

## Requirements
- R1: After reset every register, the in-service state, `irq_o`, `fiq_o` and `bus_rdata` read as zero.
- R2: A write to 0x010 sets the enable bits where the data is 1. A write to 0x014 clears them where the data is 1. Zero data bits leave a bit unchanged. A read of 0x010 returns the enable mask.
- R3: Writes to 0x018 set soft-request bits and writes to 0x01C clear them, with the same one-bit semantics as R2. A read of 0x018 returns the soft bits. A read of 0x008 returns the hardware inputs ORed with the soft bits.
- R4: The select register at 0x00C (reset 0) routes each source: 1 means fast, 0 means normal. Offset 0x000 reads the enabled, pending, normal-routed sources and offset 0x004 reads the fast ones. `fiq_o` is the OR of the fast set, registered once.
- R5: The slot control words sit at 0x200+4*i and the slot handler addresses at 0x100+4*i. In a control word, bit 5 enables the slot and bits 4:0 name its source. A slot whose enable bit is 0 has no effect.
- R6: A read of the vector register at 0x030 returns the address of the lowest-numbered eligible active slot and puts that slot into service. A request that rises in the same cycle as the read takes part in that choice.
- R7: The default address register is at 0x034. A vector read returns the default address when the only active normal sources are sources that no enabled slot covers and nothing is in service; the default level then enters service.
- R8: While a level is in service, only slots with a lower number are eligible. `irq_o` (registered once) shows only eligible requests. A vector read that finds nothing eligible returns the address of the level in service and changes nothing.
- R9: Any write to 0x030 takes the most urgent level out of service. Repeated read/acknowledge pairs unwind the nesting back to idle.
- R10: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the parameter `ID_WORD` in bits 7:0. The default is 0x0005A1C3, which gives vendor code 0x5A in bits 19:12.
- R11: The protect register (0x020, bit 0) and the test register (0x024, bits 1:0) can be written and read back, and both reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| hw_req | input | 32 | Level-sensitive hardware requests |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |
| vec_addr_o | output | 32 | Registered copy of the address that a vector read would return |

## Verification
A vector read and a change on a hardware line can fall in the same cycle. To provoke this, the bench raises a request for a more urgent slot on the clock edge that captures the vector read. The read data must then carry that slot's handler address, and the nesting must unwind with one acknowledge. The bench also judges holding off and preemption at the ports. It checks `irq_o` and the address returned while a level is in service, both when a less urgent request arrives and when a more urgent one does.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_STAT_IRQ = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT_FIQ = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_RAW      = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SEL      = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_EN_SET   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_SW_SET   = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_SW_CLR   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_PROT     = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_TEST     = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_VEC      = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_DEF      = 12'h034;
  localparam logic [3:0]        PAGE_SLOTADR = 4'h1;
  localparam logic [3:0]        PAGE_SLOTCTL = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_ID0      = 12'hFE0;

  // control word field positions
  localparam int CTL_EN_BIT = 5;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic sel;
  } mask_wr_t;
endpackage

// File: rtl/vic_mask_unit.sv
module vic_mask_unit
  import vic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_req,
  input  mask_wr_t        wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sw_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sw_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr.en_set) en_q <= en_q | wdata;
      else if (wr.en_clr) en_q <= en_q & ~wdata;
      if (wr.sw_set) sw_q <= sw_q | wdata;
      else if (wr.sw_clr) sw_q <= sw_q & ~wdata;
      if (wr.sel) sel_q <= wdata;
    end
  end

  assign raw      = hw_req | sw_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & en_q & sel_q;
endmodule

// File: rtl/vic_vector_unit.sv
module vic_vector_unit
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  localparam int SRC_W  = $clog2(NSRC),
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_stat,
  input  logic              slot_addr_we,
  input  logic              slot_ctrl_we,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              def_we,
  input  logic [DW-1:0]     wdata,
  input  logic              vec_rd,
  input  logic              vec_ack,
  output logic [DW-1:0]     slot_addr_rd,
  output logic [DW-1:0]     slot_ctrl_rd,
  output logic [DW-1:0]     def_addr_q,
  output logic [DW-1:0]     pick_addr,
  output logic              irq_req,
  output logic [NSLOT:0]    isr_q
);
  localparam int IDLE  = NSLOT + 1;
  localparam int LVL_W = $clog2(NSLOT + 2);

  logic [DW-1:0]    slot_addr [NSLOT];
  logic             ctl_en    [NSLOT];
  logic [SRC_W-1:0] ctl_src   [NSLOT];
  logic [NSLOT-1:0] slot_act;
  logic [NSLOT-1:0] elig;
  logic [NSRC-1:0]  covered;
  logic [LVL_W-1:0] cur_lvl;
  logic [SLOT_W-1:0] win;
  logic             any_elig;
  logic             dflt_elig;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_addr[g] <= '0;
        ctl_en[g]    <= 1'b0;
        ctl_src[g]   <= '0;
      end else begin
        if (slot_addr_we && slot_idx == SLOT_W'(g)) slot_addr[g] <= wdata;
        if (slot_ctrl_we && slot_idx == SLOT_W'(g)) begin
          ctl_en[g]  <= wdata[CTL_EN_BIT];
          ctl_src[g] <= wdata[SRC_W-1:0];
        end
      end
    end
    assign slot_act[g] = ctl_en[g] & irq_stat[ctl_src[g]];
  end

  always_ff @(posedge clk) begin
    if (rst) def_addr_q <= '0;
    else if (def_we) def_addr_q <= wdata;
  end

  assign slot_addr_rd = slot_addr[slot_idx];
  always_comb begin
    slot_ctrl_rd = '0;
    slot_ctrl_rd[CTL_EN_BIT] = ctl_en[slot_idx];
    slot_ctrl_rd[SRC_W-1:0]  = ctl_src[slot_idx];
  end

  // sources named by an enabled slot
  always_comb begin
    covered = '0;
    for (int i = 0; i < NSLOT; i++)
      if (ctl_en[i]) covered[ctl_src[i]] = 1'b1;
  end

  // most urgent level in service (IDLE when none)
  always_comb begin
    cur_lvl = LVL_W'(IDLE);
    for (int i = NSLOT; i >= 0; i--)
      if (isr_q[i]) cur_lvl = LVL_W'(i);
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      elig[i] = slot_act[i] && (LVL_W'(i) < cur_lvl);
  end

  always_comb begin
    win = '0;
    any_elig = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (elig[i]) begin
        win = SLOT_W'(i);
        any_elig = 1'b1;
      end
  end

  assign dflt_elig = (|(irq_stat & ~covered)) && (cur_lvl == LVL_W'(IDLE));
  assign irq_req   = any_elig | dflt_elig;

  always_comb begin
    if (any_elig)                      pick_addr = slot_addr[win];
    else if (dflt_elig)                pick_addr = def_addr_q;
    else if (cur_lvl < LVL_W'(NSLOT))  pick_addr = slot_addr[cur_lvl[SLOT_W-1:0]];
    else                               pick_addr = def_addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
    end else if (vec_rd) begin
      if (any_elig)       isr_q[win]   <= 1'b1;
      else if (dflt_elig) isr_q[NSLOT] <= 1'b1;
    end else if (vec_ack && cur_lvl != LVL_W'(IDLE)) begin
      isr_q[cur_lvl] <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_WORD = 32'h0005A1C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   hw_req,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [DW-1:0]     vec_addr_o
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic wr, rd;
  mask_wr_t mwr;
  logic [NSRC-1:0] en_q, sw_q, sel_q, raw, irq_stat, fiq_stat;
  logic [DW-1:0] slot_addr_rd, slot_ctrl_rd, def_addr_q, pick_addr;
  logic irq_req;
  logic [NSLOT:0] isr_q;
  logic in_slot_page, slot_addr_hit, slot_ctrl_hit;
  logic [SLOT_W-1:0] slot_idx;
  logic prot_q;
  logic [1:0] test_q;
  logic [DW-1:0] rd_next;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  assign slot_idx      = bus_addr[2 +: SLOT_W];
  assign in_slot_page  = (bus_addr[1:0] == 2'b00) &&
                         (bus_addr[7:2] < 6'(NSLOT));
  assign slot_addr_hit = in_slot_page && bus_addr[11:8] == PAGE_SLOTADR;
  assign slot_ctrl_hit = in_slot_page && bus_addr[11:8] == PAGE_SLOTCTL;

  assign mwr.en_set = wr && bus_addr == OFF_EN_SET;
  assign mwr.en_clr = wr && bus_addr == OFF_EN_CLR;
  assign mwr.sw_set = wr && bus_addr == OFF_SW_SET;
  assign mwr.sw_clr = wr && bus_addr == OFF_SW_CLR;
  assign mwr.sel    = wr && bus_addr == OFF_SEL;

  vic_mask_unit #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .hw_req(hw_req), .wr(mwr),
    .wdata(bus_wdata[NSRC-1:0]),
    .en_q(en_q), .sw_q(sw_q), .sel_q(sel_q), .raw(raw),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  vic_vector_unit #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_vec (
    .clk(clk), .rst(rst), .irq_stat(irq_stat),
    .slot_addr_we(wr && slot_addr_hit),
    .slot_ctrl_we(wr && slot_ctrl_hit),
    .slot_idx(slot_idx),
    .def_we(wr && bus_addr == OFF_DEF),
    .wdata(bus_wdata),
    .vec_rd(rd && bus_addr == OFF_VEC),
    .vec_ack(wr && bus_addr == OFF_VEC),
    .slot_addr_rd(slot_addr_rd), .slot_ctrl_rd(slot_ctrl_rd),
    .def_addr_q(def_addr_q), .pick_addr(pick_addr),
    .irq_req(irq_req), .isr_q(isr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      test_q <= '0;
    end else begin
      if (wr && bus_addr == OFF_PROT) prot_q <= bus_wdata[0];
      if (wr && bus_addr == OFF_TEST) test_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (slot_addr_hit)      rd_next = slot_addr_rd;
    else if (slot_ctrl_hit) rd_next = slot_ctrl_rd;
    else begin
      case (bus_addr)
        OFF_STAT_IRQ: rd_next = DW'(irq_stat);
        OFF_STAT_FIQ: rd_next = DW'(fiq_stat);
        OFF_RAW:      rd_next = DW'(raw);
        OFF_SEL:      rd_next = DW'(sel_q);
        OFF_EN_SET:   rd_next = DW'(en_q);
        OFF_SW_SET:   rd_next = DW'(sw_q);
        OFF_PROT:     rd_next = DW'(prot_q);
        OFF_TEST:     rd_next = DW'(test_q);
        OFF_VEC:      rd_next = pick_addr;
        OFF_DEF:      rd_next = def_addr_q;
        OFF_ID0:         rd_next = DW'(ID_WORD[7:0]);
        OFF_ID0 + 12'd4: rd_next = DW'(ID_WORD[15:8]);
        OFF_ID0 + 12'd8: rd_next = DW'(ID_WORD[23:16]);
        OFF_ID0 + 12'd12: rd_next = DW'(ID_WORD[31:24]);
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      if (rd) bus_rdata <= rd_next;
      irq_o      <= irq_req;
      fiq_o      <= |fiq_stat;
      vec_addr_o <= pick_addr;
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   fiq_stat,
  input logic [NSRC-1:0]   en_q,
  input logic [NSLOT:0]    isr_q,
  input logic              irq_req
);
  logic vec_rd, vec_ack, en_clr;
  assign vec_rd  = bus_en && !bus_we && bus_addr == OFF_VEC;
  assign vec_ack = bus_en && bus_we && bus_addr == OFF_VEC;
  assign en_clr  = bus_en && bus_we && bus_addr == OFF_EN_CLR;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (isr_q == '0 && en_q == '0 && !irq_o && !fiq_o));

  // R2
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    en_clr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  // R4
  fast_line_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fiq_o == (|$past(fiq_stat))));

  // R6
  push_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && irq_req) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R8
  no_push_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_rd |=> ($countones(isr_q) <= $countones($past(isr_q))));

  // R9
  ack_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

bind vic_top vic_chk #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .fiq_stat(fiq_stat), .en_q(en_q), .isr_q(isr_q), .irq_req(irq_req)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] hw_req;
  logic        irq_o, fiq_o;
  logic [31:0] vec_addr_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] v;

  vic_top dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_req(hw_req), .irq_o(irq_o), .fiq_o(fiq_o), .vec_addr_o(vec_addr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  // read with a hardware change in the same cycle
  task automatic rd_req(input logic [11:0] a, input logic [31:0] nreq, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; hw_req = nreq;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_lines(input string req, input logic ei, input logic ef);
    @(negedge clk);
    chk({req, " irq_o"}, {31'd0, irq_o}, {31'd0, ei});
    chk({req, " fiq_o"}, {31'd0, fiq_o}, {31'd0, ef});
  endtask

  task automatic t_reset;
    rd(12'h010, v); chk("R1 enable", v, 32'h0);
    rd(12'h00C, v); chk("R1 select", v, 32'h0);
    rd(12'h020, v); chk("R11 protect reset", v, 32'h0);
    rd(12'h024, v); chk("R11 test reset", v, 32'h0);
    chk_lines("R1", 1'b0, 1'b0);
    rd(12'h030, v); chk("R1 vector idle", v, 32'h0);
  endtask

  task automatic t_mask;
    wr(12'h010, 32'h0000_00F0); rd(12'h010, v); chk("R2 set", v, 32'h0000_00F0);
    wr(12'h010, 32'h0000_0003); rd(12'h010, v); chk("R2 set keeps", v, 32'h0000_00F3);
    wr(12'h014, 32'h0000_0030); rd(12'h010, v); chk("R2 clear", v, 32'h0000_00C3);
    wr(12'h014, 32'h0);         rd(12'h010, v); chk("R2 zero clear", v, 32'h0000_00C3);
  endtask

  task automatic t_soft;
    hw_req = 32'h0000_0100;
    wr(12'h018, 32'h5);  rd(12'h018, v); chk("R3 soft set", v, 32'h5);
    rd(12'h008, v); chk("R3 raw or", v, 32'h105);
    wr(12'h01C, 32'h1);  rd(12'h018, v); chk("R3 soft clear", v, 32'h4);
    wr(12'h01C, 32'hFFFF_FFFF); hw_req = 32'h0;
    wr(12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_select;
    hw_req = 32'h0000_000C;
    wr(12'h010, 32'h0000_000C);
    wr(12'h00C, 32'h0000_0008);
    rd(12'h000, v); chk("R4 normal status", v, 32'h4);
    rd(12'h004, v); chk("R4 fast status", v, 32'h8);
    chk_lines("R4 both", 1'b1, 1'b1);
    hw_req = 32'h0000_0004;
    chk_lines("R4 fast gone", 1'b1, 1'b0);
    hw_req = 32'h0;
    chk_lines("R4 idle", 1'b0, 1'b0);
    wr(12'h00C, 32'h0);
    wr(12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_vector;
    wr(12'h034, 32'd32);
    wr(12'h200, 32'h27); wr(12'h100, 32'hA000);   // slot 0 -> src 7
    wr(12'h20C, 32'h22); wr(12'h10C, 32'hA300);   // slot 3 -> src 2
    wr(12'h214, 32'h29); wr(12'h114, 32'hA500);   // slot 5 -> src 9
    wr(12'h204, 32'h0C); wr(12'h104, 32'hA100);   // slot 1 disabled, src 12
    rd(12'h204, v); chk("R5 ctrl readback", v, 32'h0C);
    rd(12'h114, v); chk("R5 addr readback", v, 32'hA500);
    wr(12'h010, 32'h0000_1284);

    hw_req = 32'h0000_0204;
    rd(12'h030, v); chk("R6 priority pick", v, 32'hA300);
    chk_lines("R8 lower held off", 1'b0, 1'b0);
    rd(12'h030, v); chk("R8 stable in service", v, 32'hA300);
    hw_req = 32'h0000_0284;
    chk_lines("R8 higher raises", 1'b1, 1'b0);
    rd(12'h030, v); chk("R8 preempt", v, 32'hA000);
    wr(12'h030, 32'h0);
    hw_req = 32'h0000_0204;
    rd(12'h030, v); chk("R9 back to level", v, 32'hA300);
    wr(12'h030, 32'h0);
    hw_req = 32'h0000_0200;
    rd(12'h030, v); chk("R9 unwound", v, 32'hA500);
    wr(12'h030, 32'h0);

    hw_req = 32'h0000_1000;
    rd(12'h030, v); chk("R7 default", v, 32'd32);
    chk_lines("R7 default in service", 1'b0, 1'b0);
    hw_req = 32'h0000_1200;
    rd(12'h030, v); chk("R8 slot over default", v, 32'hA500);
    wr(12'h030, 32'h0);
    wr(12'h030, 32'h0);
    hw_req = 32'h0;
    rd(12'h030, v); chk("R9 idle default", v, 32'd32);
    chk_lines("R9 idle lines", 1'b0, 1'b0);

    hw_req = 32'h0000_0200;
    rd_req(12'h030, 32'h0000_0280, v); chk("R6 same-cycle request", v, 32'hA000);
    wr(12'h030, 32'h0);
    hw_req = 32'h0;
    chk_lines("R9 single ack clears", 1'b0, 1'b0);
  endtask

  task automatic t_id;
    logic [31:0] id;
    id = '0;
    for (int k = 0; k < 4; k++) begin
      rd(12'hFE0 + 12'(4 * k), v);
      id[8*k +: 8] = v[7:0];
      chk("R10 id upper zero", {8'd0, v[31:8]}, 32'h0);
    end
    chk("R10 id word", id, 32'h0005A1C3);
    chk("R10 vendor", {24'd0, id[19:12]}, 32'h5A);
  endtask

  task automatic t_prot;
    wr(12'h020, 32'h1); rd(12'h020, v); chk("R11 protect", v, 32'h1);
    wr(12'h024, 32'h3); rd(12'h024, v); chk("R11 test", v, 32'h3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; hw_req = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_soft();
    t_select();
    t_vector();
    t_id();
    t_prot();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule